// File: doc/BRIEF.md
# Wide-Register CSR Multiplexer with Atomic Shadowing

This block places several control/status registers behind one narrow CSR bus. Each register covers a run of consecutive bus addresses, one bus-width chunk per address, with the least significant chunk at the lowest address. Registers are packed back to back from address 0. Software that reads or writes a register wider than the bus sees one coherent value, because the block keeps read and write shadow copies for each register.

A read of a register's first chunk raises that register's read strobe and copies its whole value into the read shadow. Later reads of the higher chunks are served from that copy, so a value that changes between chunk reads cannot produce a torn result. A write to any chunk except the top one only fills a write shadow byte. A write to the top chunk sends the full assembled value to the register with a one-cycle write strobe.

The sequencing is handled by a three-state controller. `PH_IDLE` is the state after reset and after any cycle with no read and no committing write. Any bus read moves the controller to `PH_RD_RESP`, and the read byte appears on the cycle after the read. A write to a top chunk that is not overridden by a read moves it to `PH_WR_COMMIT`, where the element write strobe is raised. From every state, the next state depends only on the current bus request: a read goes to `PH_RD_RESP`, a committing write goes to `PH_WR_COMMIT`, and anything else goes to `PH_IDLE`.

Top module: `csr_shadow_mux`

## Requirements
- R1: The 4-bit field i of `CHUNK_MAP` (bits 4i+3..4i) gives the chunk count of register i. Register 0 starts at address 0, and each later register starts where the previous one ends. The default {4,2,1} maps register 0 to address 0, register 1 to addresses 1–2 and register 2 to addresses 3–6. Register i uses bit i of each strobe vector and bits i*MAX_W+MAX_W-1..i*MAX_W of each element data vector.
- R2: A bus read of a register's chunk 0 raises `elem_rd_stb` bit i in the same cycle, for that cycle only. In the next cycle, `bus_rd_data` holds the low byte of `elem_rd_data` as it was in the read cycle.
- R3: A read of chunk 0 captures the whole register. A later read of chunk k>0 returns byte k of that captured value on the next cycle and raises no read strobe, even if the register has changed since the capture.
- R4: A write to a chunk below the top chunk stores the byte in the register's write shadow and raises no write strobe.
- R5: A write to the top chunk raises `elem_wr_stb` bit i for exactly the next cycle. In that cycle, element i's write data is the new byte in the top chunk position, the buffered bytes below it, and zeros above the register's width. Buffered bytes are kept after a commit.
- R6: A one-chunk register has its read strobe raised by any read of its address and its write committed by any write to its address.
- R7: A read of an address beyond the last register returns 0. A write to such an address raises no strobe and leaves every shadow unchanged.
- R8: `bus_rd_data` changes only in the cycle after a bus read and keeps its value otherwise.
- R9: When the read and write strobes are both high, the read is performed and the write is dropped. No write strobe is raised and no shadow byte is written.
- R10: Each strobe vector has at most one bit set, and no element strobe is raised in a cycle after a cycle with no matching bus request.
- R11: During and after reset, all element strobes are low, `bus_rd_data` is 0, and every shadow byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus chunk address |
| bus_rd_stb | input | 1 | Bus read request, one cycle per access |
| bus_wr_stb | input | 1 | Bus write request, one cycle per access |
| bus_wr_data | input | BUS_W | Bus write byte |
| bus_rd_data | output | BUS_W | Read byte, valid the cycle after a read |
| elem_rd_data | input | NUM_REGS*MAX_W | Current value of every register, register i in slice i |
| elem_rd_stb | output | NUM_REGS | Per-register read capture strobe |
| elem_wr_data | output | NUM_REGS*MAX_W | Committed value offered to each register |
| elem_wr_stb | output | NUM_REGS | Per-register write commit strobe |

## Verification
The bench uses the default parameters: an 8-bit bus, 10-bit addresses, and a map of one 8-bit, one 16-bit and one 32-bit register in 4-chunk slots. This gives a one-chunk register, a register whose only shadowed byte sits directly below its top chunk, and a register with three buffered bytes. The bench can therefore check partial recommits and stale captured bytes at every offset. Addresses 7 to 1023 are unmapped, so the bench also tests unmapped reads and writes at the top of the space.

// File: rtl/csr_mux_pkg.sv
package csr_mux_pkg;

    localparam int unsigned FIELD_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_RD_RESP   = 2'd1,
        PH_WR_COMMIT = 2'd2
    } phase_t;

    // chunk count of register idx from a packed 4-bit-per-register map
    function automatic int unsigned field_of(input logic [63:0] map, input int unsigned idx);
        return {28'd0, map[idx*FIELD_W +: FIELD_W]};
    endfunction

    // first address of register idx (sum of the counts below it)
    function automatic int unsigned chunk_base(input logic [63:0] map, input int unsigned idx);
        int unsigned acc;
        acc = 0;
        for (int unsigned j = 0; j < idx; j++) begin
            acc = acc + field_of(map, j);
        end
        return acc;
    endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_mux_pkg::*;
#(
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned NUM_REGS = 3,
    parameter logic [63:0] MAP      = 64'h421,
    parameter int unsigned IDX_W    = 2,
    parameter int unsigned OFF_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic [OFF_W-1:0]  off,
    output logic              last
);

    logic [NUM_REGS-1:0] in_rng;
    logic [NUM_REGS-1:0] at_top;
    logic [OFF_W-1:0]    rel_off [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_win
        localparam int unsigned       BASE   = chunk_base(MAP, i);
        localparam int unsigned       CNT    = field_of(MAP, i);
        localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
        logic [ADDR_W-1:0] rel;
        assign rel        = addr - BASE_A;
        assign in_rng[i]  = (addr >= BASE_A) && (rel < ADDR_W'(CNT));
        assign at_top[i]  = (rel == ADDR_W'(CNT - 1));
        assign rel_off[i] = rel[OFF_W-1:0];
    end

    // windows are disjoint, so at most one index matches
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        off  = '0;
        last = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (in_rng[i]) begin
                hit  = 1'b1;
                idx  = IDX_W'(i);
                off  = rel_off[i];
                last = at_top[i];
            end
        end
    end

endmodule

// File: rtl/csr_shadow_slot.sv
module csr_shadow_slot #(
    parameter  int unsigned BUS_W      = 8,
    parameter  int unsigned CHUNKS     = 2,
    parameter  int unsigned MAX_CHUNKS = 4,
    parameter  int unsigned OFF_W      = 2,
    localparam int unsigned MAX_W      = BUS_W * MAX_CHUNKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [MAX_W-1:0] live_val,
    input  logic [OFF_W-1:0] rd_off,
    output logic [BUS_W-1:0] rd_byte,
    input  logic             buf_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [BUS_W-1:0] wr_byte,
    output logic [MAX_W-1:0] commit_val
);

    logic [BUS_W-1:0] pick [MAX_CHUNKS];

    // chunk 0 is always served live; its capture is never read back
    assign pick[0] = live_val[BUS_W-1:0];

    for (genvar c = 1; c < MAX_CHUNKS; c++) begin : g_rd
        if (c < CHUNKS) begin : g_hold
            logic [BUS_W-1:0] cap_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cap_q <= '0;
                end else if (cap_en) begin
                    cap_q <= live_val[c*BUS_W +: BUS_W];
                end
            end
            assign pick[c] = cap_q;
        end else begin : g_pad
            logic unused_live;
            assign unused_live = ^live_val[c*BUS_W +: BUS_W];
            assign pick[c]     = '0;
        end
    end

    assign rd_byte = pick[rd_off];

    for (genvar c = 0; c < MAX_CHUNKS; c++) begin : g_wr
        if (c + 1 < CHUNKS) begin : g_buf
            logic [BUS_W-1:0] buf_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    buf_q <= '0;
                end else if (buf_en && (wr_off == OFF_W'(c))) begin
                    buf_q <= wr_byte;
                end
            end
            assign commit_val[c*BUS_W +: BUS_W] = buf_q;
        end else if (c + 1 == CHUNKS) begin : g_top
            assign commit_val[c*BUS_W +: BUS_W] = wr_byte;
        end else begin : g_zero
            assign commit_val[c*BUS_W +: BUS_W] = '0;
        end
    end

    if (CHUNKS == 1) begin : g_single
        logic unused_ctl;
        assign unused_ctl = ^{clk, rst_n, cap_en, buf_en, wr_off};
    end

endmodule

// File: rtl/csr_shadow_mux.sv
module csr_shadow_mux
    import csr_mux_pkg::*;
#(
    parameter  int unsigned              BUS_W      = 8,
    parameter  int unsigned              ADDR_W     = 10,
    parameter  int unsigned              NUM_REGS   = 3,
    parameter  int unsigned              MAX_CHUNKS = 4,
    parameter  logic [NUM_REGS*4-1:0]    CHUNK_MAP  = {4'd4, 4'd2, 4'd1},
    localparam int unsigned              MAX_W      = BUS_W * MAX_CHUNKS,
    localparam int unsigned              IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int unsigned              OFF_W      = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_rd_stb,
    input  logic                      bus_wr_stb,
    input  logic [BUS_W-1:0]          bus_wr_data,
    output logic [BUS_W-1:0]          bus_rd_data,
    input  logic [NUM_REGS*MAX_W-1:0] elem_rd_data,
    output logic [NUM_REGS-1:0]       elem_rd_stb,
    output logic [NUM_REGS*MAX_W-1:0] elem_wr_data,
    output logic [NUM_REGS-1:0]       elem_wr_stb
);

    localparam logic [63:0] MAP64 = 64'(CHUNK_MAP);

    // ---------------- address decode ----------------
    logic             hit;
    logic             at_top;
    logic [IDX_W-1:0] sel_idx;
    logic [OFF_W-1:0] sel_off;

    csr_addr_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_REGS(NUM_REGS),
        .MAP     (MAP64),
        .IDX_W   (IDX_W),
        .OFF_W   (OFF_W)
    ) u_dec (
        .addr(bus_addr),
        .hit (hit),
        .idx (sel_idx),
        .off (sel_off),
        .last(at_top)
    );

    // ---------------- request qualification ----------------
    logic rd_go;
    logic wr_go;
    logic commit_go;

    assign rd_go     = bus_rd_stb;
    assign wr_go     = bus_wr_stb & ~bus_rd_stb;   // read takes the cycle
    assign commit_go = wr_go & hit & at_top;

    // ---------------- per-register shadows ----------------
    logic [BUS_W-1:0]    slot_rd     [NUM_REGS];
    logic [MAX_W-1:0]    slot_commit [NUM_REGS];
    logic [NUM_REGS-1:0] cap_vec;
    logic [NUM_REGS-1:0] buf_vec;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        assign cap_vec[i] = rd_go && hit && (sel_idx == IDX_W'(i)) && (sel_off == '0);
        assign buf_vec[i] = wr_go && hit && (sel_idx == IDX_W'(i)) && !at_top;

        csr_shadow_slot #(
            .BUS_W     (BUS_W),
            .CHUNKS    (field_of(MAP64, i)),
            .MAX_CHUNKS(MAX_CHUNKS),
            .OFF_W     (OFF_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .cap_en    (cap_vec[i]),
            .live_val  (elem_rd_data[i*MAX_W +: MAX_W]),
            .rd_off    (sel_off),
            .rd_byte   (slot_rd[i]),
            .buf_en    (buf_vec[i]),
            .wr_off    (sel_off),
            .wr_byte   (bus_wr_data),
            .commit_val(slot_commit[i])
        );
    end

    assign elem_rd_stb = cap_vec;

    logic [BUS_W-1:0] rd_byte_next;
    assign rd_byte_next = hit ? slot_rd[sel_idx] : '0;

    // ---------------- controller ----------------
    phase_t phase_q;
    phase_t phase_d;

    always_comb begin
        phase_d = PH_IDLE;
        if (rd_go) begin
            phase_d = PH_RD_RESP;
        end else if (commit_go) begin
            phase_d = PH_WR_COMMIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // ---------------- datapath registers ----------------
    logic [BUS_W-1:0] rd_data_q;
    logic [MAX_W-1:0] commit_q;
    logic [IDX_W-1:0] wr_idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
            commit_q  <= '0;
            wr_idx_q  <= '0;
        end else begin
            if (rd_go) begin
                rd_data_q <= rd_byte_next;
            end
            if (commit_go) begin
                commit_q <= slot_commit[sel_idx];
                wr_idx_q <= sel_idx;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        elem_wr_stb = '0;
        unique case (phase_q)
            PH_IDLE:      ;
            PH_RD_RESP:   ;
            PH_WR_COMMIT: elem_wr_stb[wr_idx_q] = 1'b1;
            default:      ;
        endcase
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_wdat
        assign elem_wr_data[i*MAX_W +: MAX_W] = commit_q;
    end

    assign bus_rd_data = rd_data_q;

endmodule

// File: rtl/csr_shadow_mux_chk.sv
module csr_shadow_mux_chk
    import csr_mux_pkg::*;
#(
    parameter  int unsigned ADDR_W   = 10,
    parameter  int unsigned BUS_W    = 8,
    parameter  int unsigned NUM_REGS = 3,
    parameter  logic [63:0] MAP64    = 64'h421,
    localparam int unsigned TOTAL    = chunk_base(MAP64, NUM_REGS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_rd_stb,
    input logic                bus_wr_stb,
    input logic [BUS_W-1:0]    bus_rd_data,
    input logic [NUM_REGS-1:0] elem_rd_stb,
    input logic [NUM_REGS-1:0] elem_wr_stb
);

    logic unmapped;
    assign unmapped = (bus_addr >= ADDR_W'(TOTAL));

    assert_rd_stb_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(elem_rd_stb));

    assert_wr_stb_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(elem_wr_stb));

    assert_rd_stb_needs_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|elem_rd_stb) |-> bus_rd_stb);

    assert_wr_stb_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|elem_wr_stb) |-> $past(bus_wr_stb && !bus_rd_stb));

    assert_unmapped_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_stb && unmapped) |=> (bus_rd_data == '0));

    assert_unmapped_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_stb && !bus_rd_stb && unmapped) |=> (elem_wr_stb == '0));

    assert_rd_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_stb |=> $stable(bus_rd_data));

    assert_read_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_stb && bus_wr_stb) |=> (elem_wr_stb == '0));

endmodule

bind csr_shadow_mux csr_shadow_mux_chk #(
    .ADDR_W  (ADDR_W),
    .BUS_W   (BUS_W),
    .NUM_REGS(NUM_REGS),
    .MAP64   (64'(CHUNK_MAP))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd_stb (bus_rd_stb),
    .bus_wr_stb (bus_wr_stb),
    .bus_rd_data(bus_rd_data),
    .elem_rd_stb(elem_rd_stb),
    .elem_wr_stb(elem_wr_stb)
);

// File: tb/csr_shadow_mux_tb.sv
module csr_shadow_mux_tb;

    localparam int unsigned BUS_W      = 8;
    localparam int unsigned ADDR_W     = 10;
    localparam int unsigned NUM_REGS   = 3;
    localparam int unsigned MAX_CHUNKS = 4;
    localparam int unsigned MAX_W      = BUS_W * MAX_CHUNKS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [ADDR_W-1:0]         bus_addr;
    logic                      bus_rd_stb;
    logic                      bus_wr_stb;
    logic [BUS_W-1:0]          bus_wr_data;
    logic [BUS_W-1:0]          bus_rd_data;
    logic [NUM_REGS*MAX_W-1:0] elem_rd_data;
    logic [NUM_REGS-1:0]       elem_rd_stb;
    logic [NUM_REGS*MAX_W-1:0] elem_wr_data;
    logic [NUM_REGS-1:0]       elem_wr_stb;

    logic [MAX_W-1:0] model_val [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            elem_rd_data[i*MAX_W +: MAX_W] = model_val[i];
        end
    end

    csr_shadow_mux u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_rd_stb  (bus_rd_stb),
        .bus_wr_stb  (bus_wr_stb),
        .bus_wr_data (bus_wr_data),
        .bus_rd_data (bus_rd_data),
        .elem_rd_data(elem_rd_data),
        .elem_rd_stb (elem_rd_stb),
        .elem_wr_data(elem_wr_data),
        .elem_wr_stb (elem_wr_stb)
    );

    // ---------------- scoreboard ----------------
    typedef enum int {E_RSTB, E_RDATA, E_WSTB} ekind_t;
    typedef struct {
        int                  due;
        ekind_t              kind;
        logic [NUM_REGS-1:0] mask;
        logic [MAX_W-1:0]    data;
        string               tag;
    } exp_t;

    exp_t sb[$];
    int   cyc    = 0;
    int   n_chk  = 0;
    int   n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [MAX_W-1:0] act,
                         input logic [MAX_W-1:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp_v, cyc);
        end
    endtask

    task automatic push(input int due, input ekind_t k, input logic [NUM_REGS-1:0] m,
                        input logic [MAX_W-1:0] d, input string tag);
        exp_t e;
        e.due  = due;
        e.kind = k;
        e.mask = m;
        e.data = d;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // monitor: compares everything that is due, away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                case (e.kind)
                    E_RSTB: check(elem_rd_stb == e.mask, {e.tag, " rd strobe"},
                                  MAX_W'(elem_rd_stb), MAX_W'(e.mask));
                    E_RDATA: check(bus_rd_data == e.data[BUS_W-1:0], {e.tag, " rd data"},
                                   MAX_W'(bus_rd_data), e.data);
                    default: begin
                        check(elem_wr_stb == e.mask, {e.tag, " wr strobe"},
                              MAX_W'(elem_wr_stb), MAX_W'(e.mask));
                        for (int i = 0; i < NUM_REGS; i++) begin
                            if (e.mask[i]) begin
                                check(elem_wr_data[i*MAX_W +: MAX_W] == e.data, {e.tag, " wr data"},
                                      elem_wr_data[i*MAX_W +: MAX_W], e.data);
                            end
                        end
                    end
                endcase
            end
        end
    end

    // ---------------- driver ----------------
    task automatic bus_op(input logic rd, input logic wr, input logic [ADDR_W-1:0] a,
                          input logic [BUS_W-1:0] d);
        @(posedge clk);
        #1;
        bus_rd_stb  = rd;
        bus_wr_stb  = wr;
        bus_addr    = a;
        bus_wr_data = d;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] exp_b,
                      input logic [NUM_REGS-1:0] rmask, input string tag);
        bus_op(1'b1, 1'b0, a, '0);
        push(cyc,     E_RSTB,  rmask, '0,            tag);
        push(cyc + 1, E_RDATA, '0,    MAX_W'(exp_b), tag);
        push(cyc + 1, E_WSTB,  '0,    '0,            {tag, " R10"});
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d,
                      input logic [NUM_REGS-1:0] wmask, input logic [MAX_W-1:0] wdata,
                      input string tag);
        bus_op(1'b0, 1'b1, a, d);
        push(cyc,     E_RSTB, '0,    '0,    {tag, " R10"});
        push(cyc + 1, E_WSTB, wmask, wdata, tag);
    endtask

    task automatic both(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d,
                        input logic [BUS_W-1:0] exp_b, input logic [NUM_REGS-1:0] rmask,
                        input string tag);
        bus_op(1'b1, 1'b1, a, d);
        push(cyc,     E_RSTB,  rmask, '0,            tag);
        push(cyc + 1, E_RDATA, '0,    MAX_W'(exp_b), tag);
        push(cyc + 1, E_WSTB,  '0,    '0,            tag);
    endtask

    task automatic idle_hold(input logic [BUS_W-1:0] exp_b, input string tag);
        bus_op(1'b0, 1'b0, '0, '0);
        push(cyc,     E_RSTB,  '0, '0,            {tag, " R10"});
        push(cyc + 1, E_RDATA, '0, MAX_W'(exp_b), tag);
        push(cyc + 1, E_WSTB,  '0, '0,            {tag, " R10"});
    endtask

    task automatic set_val(input int idx, input logic [MAX_W-1:0] v);
        bus_op(1'b0, 1'b0, '0, '0);
        model_val[idx] = v;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        bus_addr    = '0;
        bus_rd_stb  = 1'b0;
        bus_wr_stb  = 1'b0;
        bus_wr_data = '0;
        for (int i = 0; i < NUM_REGS; i++) model_val[i] = '0;

        repeat (3) @(negedge clk);
        // R11: reset state
        check(elem_wr_stb == '0, "R11 wr strobe in reset", MAX_W'(elem_wr_stb), '0);
        check(elem_rd_stb == '0, "R11 rd strobe in reset", MAX_W'(elem_rd_stb), '0);
        check(bus_rd_data == '0, "R11 rd data in reset", MAX_W'(bus_rd_data), '0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R11: shadow empty before any capture
        rd(10'd2, 8'h00, 3'b000, "R11 high chunk before capture");

        // writes: one-chunk, then two-chunk
        wr(10'd0, 8'h55, 3'b001, 32'h0000_0055, "R6 single chunk commit");
        wr(10'd1, 8'hAA, 3'b000, '0,            "R4 low chunk buffered");
        wr(10'd2, 8'hBB, 3'b010, 32'h0000_BBAA, "R5 two-chunk commit");

        set_val(0, 32'h0000_0055);
        set_val(1, 32'h0000_BBAA);
        set_val(2, 32'h4433_2211);

        rd(10'd0, 8'h55, 3'b001, "R6 single chunk read");
        rd(10'd1, 8'hAA, 3'b010, "R2 low chunk capture");
        set_val(1, 32'h0000_3333);
        rd(10'd2, 8'hBB, 3'b000, "R3 stale high byte");
        rd(10'd3, 8'h11, 3'b100, "R2 four-chunk capture");
        set_val(2, 32'hAAAA_AAAA);
        rd(10'd5, 8'h33, 3'b000, "R3 offset 2 from shadow");
        rd(10'd6, 8'h44, 3'b000, "R3 offset 3 from shadow");
        rd(10'd4, 8'h22, 3'b000, "R3 offset 1 from shadow");

        idle_hold(8'h22, "R8 hold after read");
        idle_hold(8'h22, "R8 hold second idle");

        rd(10'd7,    8'h00, 3'b000, "R7 unmapped read above map");
        rd(10'd1023, 8'h00, 3'b000, "R7 unmapped read at top");

        rd(10'd3, 8'hAA, 3'b100, "R1 register 2 base at address 3");
        rd(10'd6, 8'hAA, 3'b000, "R1 register 2 top at address 6");

        wr(10'd3, 8'hDD, 3'b000, '0, "R4 offset 0 buffered");
        wr(10'd4, 8'hCC, 3'b000, '0, "R4 offset 1 buffered");
        wr(10'd5, 8'hBB, 3'b000, '0, "R4 offset 2 buffered");
        wr(10'd6, 8'hAA, 3'b100, 32'hAABB_CCDD, "R5 four-chunk commit");
        wr(10'd6, 8'h11, 3'b100, 32'h11BB_CCDD, "R5 shadow kept after commit");

        wr(10'd7,    8'hFF, 3'b000, '0, "R7 unmapped write");
        wr(10'd1,    8'h99, 3'b000, '0, "R4 low chunk rebuffered");
        wr(10'd1000, 8'h12, 3'b000, '0, "R7 unmapped write high");
        wr(10'd2,    8'h77, 3'b010, 32'h0000_7799, "R7 shadows intact after unmapped writes");

        both(10'd0, 8'h66, 8'h55, 3'b001, "R9 read wins single chunk");
        both(10'd1, 8'h42, 8'h33, 3'b010, "R9 read wins low chunk");
        wr(10'd2, 8'h10, 3'b010, 32'h0000_1099, "R9 dropped write left shadow");

        idle_hold(8'h33, "R8 final hold");
        repeat (3) bus_op(1'b0, 1'b0, '0, '0);
        @(negedge clk);
        check(sb.size() == 0, "R10 scoreboard drained", MAX_W'(sb.size()), '0);
        summary();
        $finish;
    end

endmodule